// File: doc/BRIEF.md
# Hot-Swap Board Control and Status Register

This block holds an 8-bit control and status register for a hot-swappable plug-in board. It watches the board's ejector-handle switch and the bus reset, which is the block's asynchronous reset. It records insertion and extraction events in two sticky status bits. It raises an enumeration request toward the system host. It also drives the blue hot-swap indicator LED. The raw handle input passes through a flop synchronizer. A stable-count debouncer then filters it, and only after that is any handle edge used.

Host software reaches the register through a byte-wide read/write port at a fixed address, `REG_OFFSET` (default 0xE6). Reads are combinational. A write takes effect on the rising clock edge when `reg_we` is high and `reg_addr` matches. The two event bits can only be set by hardware: insertion once per bus reset, and extraction when the handle opens while no insertion is pending. Software clears each one by writing 1 to it.

After a bus reset the LED is held on while the handle is still open. Once the debounced handle has closed, a software-owned control bit drives the LED. The enumeration request is an output enable for an active-low, open-drain pad.

Top module: `hsw_ctl_reg`

## Requirements
- R1: While reset is held and just after reset is released, the register reads 0x00, `enum_oe` is 0 and `led_o` is 1.
- R2: Only address `REG_OFFSET` (0xE6) returns register contents. Any other address reads 0x00, and writes to any other address leave the register unchanged.
- R3: Bit 7 (insertion) sets when the debounced handle is closed and bit 6 is 0. This can happen at most once between two bus resets: reopening and reclosing the handle never sets it again.
- R4: Bit 6 (extraction) sets on a debounced closed-to-open transition of the handle, but only while bit 7 is 0.
- R5: Bits 7 and 6 are write-one-to-clear. Writing 1 clears the bit, writing 0 leaves it unchanged, and software can never set either bit. If a hardware set and a software clear of the same bit fall in one cycle, the set wins.
- R6: `enum_oe` is 1 exactly when bit 7 or bit 6 is 1 and mask bit 1 is 0. Bit 1 is read/write. The mask does not stop bits 7 and 6 from latching.
- R7: From reset until the first debounced handle closure, `led_o` is 1 whatever bit 3 holds. From that closure on, `led_o` equals bit 3, which is read/write.
- R8: Bits 5, 4, 2 and 0 always read 0, and writing 1 to them has no effect.
- R9: A change of the handle input that lasts fewer than `DEB_CYCLES` synchronized cycles is ignored. It sets no event bit and does not release the LED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Bus reset, asynchronous, active low |
| handle_raw | input | 1 | Ejector-handle switch, asynchronous; closed level set by `HANDLE_ACTIVE_LOW` (default: 1 = closed) |
| reg_addr | input | 8 | Register port address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| enum_oe | output | 1 | Output enable for the active-low open-drain enumeration pad |
| led_o | output | 1 | Hot-swap LED drive, 1 = lit |

## Verification
Several rules are checked by the assertions on every cycle:
- `enum_oe` matches the pending events and the mask.
- A rise of either event bit is preceded by its hardware condition, so it can never come from a write.
- A hardware set always wins over a same-cycle clear.
- The LED stays lit until control has been granted.
- The reserved bits read 0.
- The debounced level moves only toward the synchronized input.

Some behaviour only the directed scenarios can show:
- The one-shot nature of insertion across several handle cycles.
- Glitch rejection at the debouncer.
- Address decoding.
- A second bus reset with the handle already closed producing a fresh insertion.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
   localparam int unsigned DATA_W  = 8;
   localparam int unsigned B_INS   = 7;
   localparam int unsigned B_EXT   = 6;
   localparam int unsigned B_LED   = 3;
   localparam int unsigned B_MASK  = 1;
   localparam logic [DATA_W-1:0] RSVD_BITS = 8'h35;

   typedef struct packed {
      logic ins;
      logic ext;
      logic led;
      logic mask;
   } hsw_fields_t;

   function automatic logic [DATA_W-1:0] pack_reg(hsw_fields_t f);
      logic [DATA_W-1:0] r;
      r         = '0;
      r[B_INS]  = f.ins;
      r[B_EXT]  = f.ext;
      r[B_LED]  = f.led;
      r[B_MASK] = f.mask;
      return r;
   endfunction
endpackage

// File: rtl/hsw_debounce.sv
module hsw_debounce #(
   parameter int unsigned SYNC_STAGES       = 2,
   parameter int unsigned DEB_CYCLES        = 16,
   parameter bit          HANDLE_ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic sync_o,
   output logic closed_o
);
   localparam int unsigned CNT_W = $clog2(DEB_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

   logic                   level_in;
   logic [SYNC_STAGES-1:0] sync_q;
   logic [CNT_W-1:0]       cnt_q;
   logic                   state_q;

   generate
      if (HANDLE_ACTIVE_LOW) begin : g_inv
         assign level_in = ~raw_i;
      end else begin : g_pass
         assign level_in = raw_i;
      end
   endgenerate

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= level_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         state_q <= 1'b0;
      end else if (sync_o == state_q) begin
         cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
         cnt_q   <= '0;
         state_q <= sync_o;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign closed_o = state_q;
endmodule

// File: rtl/hsw_events.sv
module hsw_events (
   input  logic clk,
   input  logic rst_n,
   input  logic closed_i,
   input  logic clr_ins_i,
   input  logic clr_ext_i,
   output logic ins_o,
   output logic ext_o,
   output logic ins_set_o,
   output logic ext_set_o,
   output logic grant_o
);
   logic ins_q, ext_q, armed_q, grant_q, prev_q;

   assign ins_set_o = armed_q & closed_i & ~ext_q;
   assign ext_set_o = prev_q & ~closed_i & ~ins_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ins_q   <= 1'b0;
         ext_q   <= 1'b0;
         armed_q <= 1'b1;
         grant_q <= 1'b0;
         prev_q  <= 1'b0;
      end else begin
         prev_q <= closed_i;
         if (ins_set_o)      ins_q <= 1'b1;
         else if (clr_ins_i) ins_q <= 1'b0;
         if (ext_set_o)      ext_q <= 1'b1;
         else if (clr_ext_i) ext_q <= 1'b0;
         if (ins_set_o)      armed_q <= 1'b0;
         if (closed_i)       grant_q <= 1'b1;
      end
   end

   assign ins_o   = ins_q;
   assign ext_o   = ext_q;
   assign grant_o = grant_q;
endmodule

// File: rtl/hsw_ctl_reg.sv
module hsw_ctl_reg #(
   parameter int unsigned ADDR_W            = 8,
   parameter logic [7:0]  REG_OFFSET        = 8'hE6,
   parameter int unsigned SYNC_STAGES       = 2,
   parameter int unsigned DEB_CYCLES        = 16,
   parameter bit          HANDLE_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              handle_raw,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              enum_oe,
   output logic              led_o
);
   import hsw_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DEB_CYCLES < 2) begin : g_bad_deb
         $error("DEB_CYCLES must be at least 2");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must hold the register offset");
      end
   endgenerate

   logic        hs_sync, closed_db;
   logic        sts_ins, sts_ext, ins_set, ext_set, grant;
   logic        mask_q, led_q;
   logic        hit, wr;
   hsw_fields_t flds;

   assign hit = (reg_addr == ADDR_W'(REG_OFFSET));
   assign wr  = hit & reg_we;

   hsw_debounce #(
      .SYNC_STAGES      (SYNC_STAGES),
      .DEB_CYCLES       (DEB_CYCLES),
      .HANDLE_ACTIVE_LOW(HANDLE_ACTIVE_LOW)
   ) u_deb (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (handle_raw),
      .sync_o  (hs_sync),
      .closed_o(closed_db)
   );

   hsw_events u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .closed_i (closed_db),
      .clr_ins_i(wr & reg_wdata[B_INS]),
      .clr_ext_i(wr & reg_wdata[B_EXT]),
      .ins_o    (sts_ins),
      .ext_o    (sts_ext),
      .ins_set_o(ins_set),
      .ext_set_o(ext_set),
      .grant_o  (grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b0;
         led_q  <= 1'b0;
      end else if (wr) begin
         mask_q <= reg_wdata[B_MASK];
         led_q  <= reg_wdata[B_LED];
      end
   end

   always_comb begin
      flds.ins  = sts_ins;
      flds.ext  = sts_ext;
      flds.led  = led_q;
      flds.mask = mask_q;
   end

   assign reg_rdata = hit ? pack_reg(flds) : 8'h00;
   assign enum_oe   = (sts_ins | sts_ext) & ~mask_q;
   assign led_o     = grant ? led_q : 1'b1;
endmodule

// File: rtl/hsw_ctl_reg_chk.sv
module hsw_ctl_reg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] reg_rdata,
   input logic       enum_oe,
   input logic       led_o,
   input logic       hs_sync,
   input logic       closed_db,
   input logic       sts_ins,
   input logic       sts_ext,
   input logic       ins_set,
   input logic       ext_set,
   input logic       grant,
   input logic       mask_q
);
   // R6
   enum_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enum_oe |-> ((sts_ins || sts_ext) && !mask_q));
   // R6
   enum_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts_ins || sts_ext) && !mask_q) |-> enum_oe);
   // R3
   ins_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_ins) |-> ($past(closed_db) && !$past(sts_ext)));
   // R4
   ext_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_ext) |-> (!$past(closed_db) && !$past(sts_ins)));
   // R5
   ins_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_set |=> sts_ins);
   // R5
   ext_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_set |=> sts_ext);
   // R7
   led_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |-> led_o);
   // R7
   grant_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(grant) |-> grant);
   // R8
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & hsw_pkg::RSVD_BITS) == 8'h00);
   // R9
   deb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(closed_db) |-> (closed_db == $past(hs_sync)));
endmodule

bind hsw_ctl_reg hsw_ctl_reg_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_rdata(reg_rdata),
   .enum_oe  (enum_oe),
   .led_o    (led_o),
   .hs_sync  (hs_sync),
   .closed_db(closed_db),
   .sts_ins  (sts_ins),
   .sts_ext  (sts_ext),
   .ins_set  (ins_set),
   .ext_set  (ext_set),
   .grant    (grant),
   .mask_q   (mask_q)
);

// File: tb/hsw_ctl_reg_tb_top.sv
module hsw_ctl_reg_tb_top;
   localparam int unsigned DEB    = 8;
   localparam logic [7:0]  OFF    = 8'hE6;
   localparam int unsigned SETTLE = DEB + 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       handle_raw = 1'b0;
   logic [7:0] reg_addr = OFF;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       enum_oe, led_o;

   int unsigned vectors = 0;
   int unsigned miscompares = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   hsw_ctl_reg #(.DEB_CYCLES(DEB)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .handle_raw(handle_raw),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .enum_oe   (enum_oe),
      .led_o     (led_o)
   );

   task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
      end
   endtask

   task automatic idle(int unsigned n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = OFF;
   endtask

   task automatic rd_check(string req, logic [7:0] a, logic [7:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, "read", reg_rdata, exp);
      reg_addr = OFF;
   endtask

   task automatic pins_check(string req, logic exp_enum, logic exp_led);
      @(negedge clk);
      #1;
      check(req, "enum_oe", {7'd0, enum_oe}, {7'd0, exp_enum});
      check(req, "led_o", {7'd0, led_o}, {7'd0, exp_led});
   endtask

   task automatic do_reset(logic handle_lvl);
      @(negedge clk);
      rst_n = 1'b0;
      handle_raw = handle_lvl;
      idle(3);
      #1;
      check("R1", "rdata in reset", reg_rdata, 8'h00);
      check("R1", "enum in reset", {7'd0, enum_oe}, 8'h00);
      check("R1", "led in reset", {7'd0, led_o}, 8'h01);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset(1'b0);
      rd_check("R1", OFF, 8'h00);
      pins_check("R1", 1'b0, 1'b1);
   endtask

   task automatic t_sw_write_fields();
      wr(OFF, 8'hFF);
      rd_check("R8", OFF, 8'h0A);   // R5: event bits not settable by software
      pins_check("R7", 1'b0, 1'b1); // LED still forced
      wr(OFF, 8'h00);
      rd_check("R8", OFF, 8'h00);
   endtask

   task automatic t_addr_decode();
      wr(8'h55, 8'hFF);
      rd_check("R2", OFF, 8'h00);
      wr(OFF, 8'h0A);
      rd_check("R2", 8'h55, 8'h00);
      rd_check("R2", 8'hE7, 8'h00);
      wr(OFF, 8'h00);
   endtask

   task automatic t_glitch();
      @(negedge clk);
      handle_raw = 1'b1;
      idle(DEB / 2);
      handle_raw = 1'b0;
      idle(SETTLE);
      rd_check("R9", OFF, 8'h00);
      pins_check("R9", 1'b0, 1'b1);
   endtask

   task automatic t_insertion();
      @(negedge clk);
      handle_raw = 1'b1;
      idle(SETTLE);
      rd_check("R3", OFF, 8'h80);
      pins_check("R7", 1'b1, 1'b0);   // R6 enum on, LED now follows bit 3 = 0
   endtask

   task automatic t_mask_led();
      wr(OFF, 8'h02);
      rd_check("R6", OFF, 8'h82);
      pins_check("R6", 1'b0, 1'b0);
      wr(OFF, 8'h0A);
      pins_check("R7", 1'b0, 1'b1);
      wr(OFF, 8'h08);
      pins_check("R6", 1'b1, 1'b1);
   endtask

   task automatic t_ext_blocked();
      @(negedge clk);
      handle_raw = 1'b0;
      idle(SETTLE);
      rd_check("R4", OFF, 8'h88);
      wr(OFF, 8'h88);
      rd_check("R5", OFF, 8'h08);
      pins_check("R6", 1'b0, 1'b1);
   endtask

   task automatic t_no_reinsert_then_ext();
      @(negedge clk);
      handle_raw = 1'b1;
      idle(SETTLE);
      rd_check("R3", OFF, 8'h08);
      @(negedge clk);
      handle_raw = 1'b0;
      idle(SETTLE);
      rd_check("R4", OFF, 8'h48);
      pins_check("R6", 1'b1, 1'b1);
      wr(OFF, 8'h0A);   // mask set; extraction bit stays latched
      rd_check("R6", OFF, 8'h4A);
      wr(OFF, 8'h08);
      rd_check("R5", OFF, 8'h48);
      wr(OFF, 8'h48);
      rd_check("R5", OFF, 8'h08);
   endtask

   task automatic t_reset_closed();
      do_reset(1'b1);
      rd_check("R1", OFF, 8'h00);
      idle(SETTLE);
      rd_check("R3", OFF, 8'h80);
      pins_check("R7", 1'b1, 1'b0);
   endtask

   initial begin
      idle(2);
      t_reset_state();
      t_sw_write_fields();
      t_addr_decode();
      t_glitch();
      t_insertion();
      t_mask_led();
      t_ext_blocked();
      t_no_reinsert_then_ext();
      t_reset_closed();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule